// File: doc/BRIEF.md
# Cubic Forward-Difference Polynomial Evaluator

This block produces the values of a polynomial of degree at most three at consecutive integer points. The caller does not supply coefficients. It supplies the starting value together with the first, second and third forward differences at the starting point. From then on, every step needs one addition per order and no multiplication.

A load strobe places the four starting terms into a chain of registers. Term 0 holds the value, and term k holds the k-th difference. Each step strobe does two things in the same cycle. It presents the current value on the output with a one-cycle valid pulse. It also moves every term forward by adding the next higher term, using the old values for every order. The highest difference never changes while stepping. A quadratic, linear or constant function is evaluated by loading zero into the difference terms it does not use. All arithmetic is signed two's complement at a parameterised width and wraps on overflow.

Top module: `fdiff_eval`

## Requirements
- R1: During and after a synchronous active-high reset, `val_o` is 0 and `valid_o` is 0, and all four terms are zero, so a step right after reset outputs 0.
- R2: When `load` is high at a clock edge, the four terms take `init_terms`, where slice 0 is the value and slice k is the k-th difference. `valid_o` is 0 in the following cycle.
- R3: When `step` is high and `load` is low at an edge, `val_o` shows the value term as it stood before that edge, and `valid_o` is 1 for the following cycle only.
- R4: On a step, term k becomes term k plus term k+1 for k below 3. Every sum uses the values from before the edge. Starting from (1, 3, 8, 6), the outputs are 1, 4, 15, 40, 85, 156, 259.
- R5: The third-difference term keeps its value on every step, so the third difference of any four consecutive outputs equals the loaded third difference.
- R6: `load` takes priority over `step` when both are high. The load happens, no output is produced, and the next step outputs the newly loaded value.
- R7: In a cycle with neither `load` nor `step`, the terms and `val_o` keep their values and `valid_o` is 0.
- R8: Sums wrap modulo 2^W in two's complement. With W=36, value 0x7FFFFFFFF and first difference 1 produce 0x7FFFFFFFF followed by 0x800000000. Negative differences count downward.
- R9: A lower-order function is evaluated by loading zeros into the unused differences. Loading (0, 1, 2, 0) gives 0, 1, 4, 9, 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load strobe for the starting terms |
| step | input | 1 | Advance strobe; emits one output point |
| init_terms | input | (ORDER+1)*W | Starting terms; slice 0 is the value, slice k is the k-th difference |
| val_o | output | W | Polynomial value from the most recent step |
| valid_o | output | 1 | High for the one cycle after a step |

## Verification
The assertions check the following on every cycle:
- the valid pulse follows exactly the step-without-load cycles;
- the output holds when no step occurs;
- the highest difference is frozen while stepping and captured on load;
- the first output after a load equals the loaded value.

Only the bench scenarios can show that the additions produce the right values over longer sequences. These include the cubic and quadratic examples, the overflow wrap, downward counting with negative differences, and the combined load-and-step case. A cycle-level reference model compares every output each clock to cover those scenarios.

// File: rtl/fdiff_pkg.sv
package fdiff_pkg;

    localparam int unsigned FD_DEF_WIDTH = 36;
    localparam int unsigned FD_DEF_ORDER = 3;

    typedef enum logic [1:0] {
        FD_HOLD = 2'd0,
        FD_LOAD = 2'd1,
        FD_STEP = 2'd2
    } fd_op_e;

    function automatic fd_op_e fd_decode(input logic load, input logic step);
        if (load)
            return FD_LOAD;
        else if (step)
            return FD_STEP;
        else
            return FD_HOLD;
    endfunction

endpackage

// File: rtl/fdiff_ctrl.sv
module fdiff_ctrl
    import fdiff_pkg::*;
(
    input  logic   load,
    input  logic   step,
    output fd_op_e op
);
    always_comb begin
        op = fd_decode(load, step);
    end
endmodule

// File: rtl/fdiff_term.sv
module fdiff_term
    import fdiff_pkg::*;
#(
    parameter int unsigned W      = FD_DEF_WIDTH,
    parameter bit          IS_TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  fd_op_e       op,
    input  logic [W-1:0] init_val,
    input  logic [W-1:0] higher,
    output logic [W-1:0] q
);
    logic [W-1:0] addend;
    logic [W-1:0] nxt;

    generate
        if (IS_TOP) begin : g_top
            always_comb addend = '0;
        end else begin : g_mid
            always_comb addend = higher;
        end
    endgenerate

    always_comb begin
        unique case (op)
            FD_LOAD: nxt = init_val;
            FD_STEP: nxt = q + addend;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/fdiff_out.sv
module fdiff_out
    import fdiff_pkg::*;
#(
    parameter int unsigned W = FD_DEF_WIDTH
) (
    input  logic         clk,
    input  logic         rst,
    input  fd_op_e       op,
    input  logic [W-1:0] cur_val,
    output logic [W-1:0] val_o,
    output logic         valid_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= (op == FD_STEP);
            if (op == FD_STEP)
                val_o <= cur_val;
        end
    end
endmodule

// File: rtl/fdiff_eval.sv
module fdiff_eval
    import fdiff_pkg::*;
#(
    parameter int unsigned W     = FD_DEF_WIDTH,
    parameter int unsigned ORDER = FD_DEF_ORDER
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic                   step,
    input  logic [ORDER:0][W-1:0]  init_terms,
    output logic [W-1:0]           val_o,
    output logic                   valid_o
);
    localparam int unsigned NTERMS = ORDER + 1;

    fd_op_e       op;
    logic [W-1:0] term_q [NTERMS];

    fdiff_ctrl u_ctrl (
        .load (load),
        .step (step),
        .op   (op)
    );

    for (genvar k = 0; k < NTERMS; k++) begin : g_term
        if (k == ORDER) begin : g_hi
            fdiff_term #(.W(W), .IS_TOP(1'b1)) u_term (
                .clk      (clk),
                .rst      (rst),
                .op       (op),
                .init_val (init_terms[k]),
                .higher   (term_q[k]),
                .q        (term_q[k])
            );
        end else begin : g_lo
            fdiff_term #(.W(W), .IS_TOP(1'b0)) u_term (
                .clk      (clk),
                .rst      (rst),
                .op       (op),
                .init_val (init_terms[k]),
                .higher   (term_q[k+1]),
                .q        (term_q[k])
            );
        end
    end

    fdiff_out #(.W(W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .cur_val (term_q[0]),
        .val_o   (val_o),
        .valid_o (valid_o)
    );
endmodule

// File: rtl/fdiff_eval_chk.sv
module fdiff_eval_chk #(
    parameter int unsigned W     = 36,
    parameter int unsigned ORDER = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  load,
    input logic                  step,
    input logic [ORDER:0][W-1:0] init_terms,
    input logic [W-1:0]          val_o,
    input logic                  valid_o,
    input logic [W-1:0]          top_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!valid_o && val_o == '0)); // R1

    AST_NO_PULSE_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> !valid_o); // R2

    AST_PULSE_ON_STEP: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> valid_o); // R3

    AST_FIRST_OUT_IS_LOADED: assert property (@(posedge clk) disable iff (rst)
        load ##1 (step && !load) |=> val_o == $past(init_terms[0], 2)); // R4

    AST_TOP_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(top_q)); // R5

    AST_TOP_LOADED: assert property (@(posedge clk) disable iff (rst)
        load |=> top_q == $past(init_terms[ORDER])); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(step && !load) |=> (!valid_o && $stable(val_o))); // R7
endmodule

bind fdiff_eval fdiff_eval_chk #(.W(W), .ORDER(ORDER)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .step       (step),
    .init_terms (init_terms),
    .val_o      (val_o),
    .valid_o    (valid_o),
    .top_q      (term_q[ORDER])
);

// File: tb/fdiff_eval_tb.sv
module fdiff_eval_tb;
    localparam int W        = 36;
    localparam int ORDER    = 3;
    localparam int CLK_PER  = 10;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  load = 1'b0;
    logic                  step = 1'b0;
    logic [ORDER:0][W-1:0] init_terms = '0;
    logic [W-1:0]          val_o;
    logic                  valid_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [W-1:0] m_t [4];
    logic [W-1:0] m_val = '0;
    logic         m_vld = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    fdiff_eval #(.W(W), .ORDER(ORDER)) u_dut (
        .clk(clk), .rst(rst), .load(load), .step(step),
        .init_terms(init_terms), .val_o(val_o), .valid_o(valid_o)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural model, updated on every edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) m_t[i] = '0;
            m_val = '0;
            m_vld = 1'b0;
        end else if (load) begin
            for (int i = 0; i < 4; i++) m_t[i] = init_terms[i];
            m_vld = 1'b0;
        end else if (step) begin
            m_val = m_t[0];
            m_vld = 1'b1;
            for (int i = 0; i < 3; i++) m_t[i] = m_t[i] + m_t[i+1];
        end else begin
            m_vld = 1'b0;
        end
    end

    // per-cycle compare against the model (R3 R4 R7)
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(val_o == m_val, "R4 model value", longint'(val_o), longint'(m_val));
            chk(valid_o == m_vld, "R3 model valid", longint'(valid_o), longint'(m_vld));
        end
    end

    task automatic do_load(input logic [W-1:0] a, b, c, d);
        @(negedge clk);
        load = 1'b1;
        init_terms[0] = a; init_terms[1] = b; init_terms[2] = c; init_terms[3] = d;
        @(negedge clk);
        load = 1'b0;
        chk(valid_o == 1'b0, "R2 no pulse after load", longint'(valid_o), 0);
    endtask

    longint cub [7] = '{1, 4, 15, 40, 85, 156, 259};
    longint y   [7];

    initial begin
        repeat (3) @(negedge clk);
        chk(val_o == '0, "R1 reset value", longint'(val_o), 0);
        chk(valid_o == 1'b0, "R1 reset valid", longint'(valid_o), 0);
        rst = 1'b0;

        // R1: step right after reset outputs 0
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk(val_o == '0 && valid_o, "R1 zero state step", longint'(val_o), 0);

        // R4: cubic example
        do_load(36'd1, 36'd3, 36'd8, 36'd6);
        step = 1'b1;
        for (int t = 0; t < 7; t++) begin
            @(negedge clk);
            y[t] = longint'(val_o);
            chk(val_o == W'(cub[t]) && valid_o, "R4 cubic point", longint'(val_o), cub[t]);
        end
        step = 1'b0;
        // R5: third difference of outputs constant
        for (int t = 0; t + 3 < 7; t++)
            chk(y[t+3] - 3*y[t+2] + 3*y[t+1] - y[t] == 6, "R5 third diff",
                y[t+3] - 3*y[t+2] + 3*y[t+1] - y[t], 6);

        // R7: idle holds
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(val_o == 36'd259 && !valid_o, "R7 idle hold", longint'(val_o), 259);
        end
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk(val_o == 36'd400, "R7 resume after idle", longint'(val_o), 400);

        // R6: load and step together
        @(negedge clk);
        load = 1'b1; step = 1'b1;
        init_terms[0] = 36'd50; init_terms[1] = 36'd0;
        init_terms[2] = 36'd0;  init_terms[3] = 36'd0;
        @(negedge clk);
        load = 1'b0;
        chk(!valid_o, "R6 load wins, no pulse", longint'(valid_o), 0);
        @(negedge clk);
        step = 1'b0;
        chk(val_o == 36'd50 && valid_o, "R6 first out is new load", longint'(val_o), 50);

        // R9: quadratic by zero third difference
        do_load(36'd0, 36'd1, 36'd2, 36'd0);
        step = 1'b1;
        for (int t = 0; t < 5; t++) begin
            @(negedge clk);
            chk(val_o == W'(t*t), "R9 square point", longint'(val_o), longint'(t*t));
        end
        step = 1'b0;

        // R8: wrap at the top of the signed range
        do_load(36'h7_FFFF_FFFF, 36'd1, 36'd0, 36'd0);
        step = 1'b1;
        @(negedge clk);
        chk(val_o == 36'h7_FFFF_FFFF, "R8 max positive", longint'(val_o), 64'h7_FFFF_FFFF);
        @(negedge clk);
        step = 1'b0;
        chk(val_o == 36'h8_0000_0000, "R8 wrap to min", longint'(val_o), 64'h8_0000_0000);

        // R8: negative difference counts down through zero
        do_load(36'd2, -36'sd3, 36'd0, 36'd0);
        step = 1'b1;
        @(negedge clk);
        @(negedge clk);
        step = 1'b0;
        chk(val_o == W'(-1), "R8 negative result", longint'(val_o), longint'(W'(-1)));

        // R1: reset mid-run clears
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(val_o == '0 && !valid_o, "R1 reset clears", longint'(val_o), 0);
        rst = 1'b0;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk(val_o == '0, "R1 state cleared by reset", longint'(val_o), 0);

        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule